// File: doc/BRIEF.md
# SAR Conversion and Calibration Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. It runs from the master clock and turns a convert-start edge into a fixed-length sequence of trial codes sent to an external DAC. It reads back one comparator decision per trial and ends with a coded result word. The analog sampling stage, the DAC, the comparator and any serial port sit outside the block. The block only sees the comparator decision, which is high when the held input is at or above the trial code.

An active-low calibration input takes priority over everything else. While it is held low, all sequencing state is cleared. Its rising edge launches a calibration whose length in master clocks is fixed by a two-bit mode input. The last twelve clocks of every calibration run a binary search whose outcome is kept as a calibration word. A sleep request powers the block down, but only once no conversion or calibration is running. Both the result and the calibration word survive sleep.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, hold, powered_down, dac_code, data_out and cal_word are all zero.
- R2: A rising edge of conv_start is registered at a clock edge where the block is idle and awake. At that edge busy and hold go high, and they stay high for exactly CONV_CLKS (default 18) master clock periods.
- R3: A conversion presents trial codes MSB first, one bit decided per clock during its first 12 clocks. A bit is kept when cmp_hi is high. The result changes only at the clock edge where busy falls, and never while busy stays high.
- R4: range_bip is sampled at the start of a conversion. When low, data_out is straight binary. When high, data_out is two's complement, which is the binary code with its MSB (bit 11) inverted.
- R5: A conv_start rising edge that arrives while a conversion is running is ignored. The running conversion keeps its length and its result.
- R6: While cal_n is low, busy, hold and powered_down are low one clock later, any running operation is abandoned, data_out keeps its previous value, and conv_start edges are ignored.
- R7: A rising edge of cal_n starts a calibration. busy rises two clock periods after the clock edge that registers it and stays high for the mode's length. The mode codes are: cal_mode 00 = full self-calibration (CAL_FULL_CLKS), 01 = DAC plus full-scale (CAL_DAC_CLKS), 10 = offset only (CAL_OFS_CLKS), 11 = same as 00.
- R8: The last 12 clocks of a calibration run a binary search on cmp_hi. Its outcome, in straight binary, is loaded into cal_word at the edge where busy falls.
- R9: With sleep_n low, powered_down rises only from idle. A request made during a conversion takes effect one clock after busy falls, and powered_down and busy are never high together.
- R10: While powered_down is high, conv_start edges are ignored and data_out and cal_word are unchanged. Raising sleep_n clears powered_down at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start, acts on its rising edge |
| cal_n | input | 1 | Calibration control: low clears, rising edge starts |
| sleep_n | input | 1 | Low requests power-down |
| range_bip | input | 1 | 0 = unipolar/binary coding, 1 = bipolar/two's complement |
| cal_mode | input | 2 | Calibration kind, sampled at the cal_n edge |
| cmp_hi | input | 1 | Comparator decision for the current trial code |
| dac_code | output | 12 | Trial code for the external DAC |
| hold | output | 1 | High while a conversion holds the input |
| busy | output | 1 | Conversion or calibration in progress |
| data_out | output | 12 | Last conversion result, coded |
| cal_word | output | 12 | Stored calibration search outcome |
| powered_down | output | 1 | Block is asleep |

## Verification
A conversion edge driven before clock edge 1 raises busy at edge 1. busy stays high through edge 18, and data_out and the low busy appear after edge 19. The bench drives inputs on falling edges and samples on every following falling edge, so it counts busy periods directly and reads the result one period after the last busy sample. For calibration, busy is low after the registering edge and the next one, is high for exactly the mode length, and cal_word is read after busy falls. A sleep request made mid-conversion is checked to show powered_down one edge after busy falls. The results are compared with values the bench computes from the analog code it applies: the code itself, or that code with bit 11 inverted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CONV    = 3'd1,
        ST_CAL_DLY = 3'd2,
        ST_CAL_RUN = 3'd3,
        ST_SLEEP   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CALM_FULL  = 2'b00,
        CALM_DACFS = 2'b01,
        CALM_OFS   = 2'b10,
        CALM_ALT   = 2'b11
    } cal_mode_e;

    localparam int CAL_LEAD_CLKS = 2;

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= RST_VAL[i];
            else        prev_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q[i];
    end
endmodule

// File: rtl/adc_sar_step.sv
module adc_sar_step #(
    parameter int W     = 12,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     trial,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic             cmp,
    output logic [W-1:0]     nxt
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b < W - 1) begin : g_mid
            always_comb begin
                nxt[b] = trial[b];
                if (en && int'(idx) == W - 1 - b)      nxt[b] = trial[b] & cmp;
                else if (en && int'(idx) == W - 2 - b) nxt[b] = 1'b1;
            end
        end else begin : g_top
            always_comb begin
                nxt[b] = trial[b];
                if (en && int'(idx) == 0) nxt[b] = trial[b] & cmp;
            end
        end
    end
endmodule

// File: rtl/adc_cal_len.sv
module adc_cal_len
    import adc_seq_pkg::*;
#(
    parameter int CNT_W         = 17,
    parameter int CAL_FULL_CLKS = 125013,
    parameter int CAL_DAC_CLKS  = 111114,
    parameter int CAL_OFS_CLKS  = 13899
) (
    input  logic [1:0]       mode,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        unique case (cal_mode_e'(mode))
            CALM_DACFS: len = CNT_W'(CAL_DAC_CLKS);
            CALM_OFS:   len = CNT_W'(CAL_OFS_CLKS);
            default:    len = CNT_W'(CAL_FULL_CLKS);
        endcase
    end
endmodule

// File: rtl/adc_out_coder.sv
module adc_out_coder #(
    parameter int W = 12
) (
    input  logic [W-1:0] code,
    input  logic         bip,
    output logic [W-1:0] coded
);
    always_comb begin
        coded = code;
        if (bip) coded[W-1] = ~code[W-1];
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W         = 12,
    parameter int CONV_CLKS     = 18,
    parameter int CAL_FULL_CLKS = 125013,
    parameter int CAL_DAC_CLKS  = 111114,
    parameter int CAL_OFS_CLKS  = 13899
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             cal_n,
    input  logic             sleep_n,
    input  logic             range_bip,
    input  logic [1:0]       cal_mode,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic             hold,
    output logic             busy,
    output logic [RES_W-1:0] data_out,
    output logic [RES_W-1:0] cal_word,
    output logic             powered_down
);
    localparam int MAX_AB   = (CAL_FULL_CLKS > CAL_DAC_CLKS) ? CAL_FULL_CLKS : CAL_DAC_CLKS;
    localparam int MAX_ABC  = (MAX_AB > CAL_OFS_CLKS) ? MAX_AB : CAL_OFS_CLKS;
    localparam int MAX_CLKS = (MAX_ABC > CONV_CLKS) ? MAX_ABC : CONV_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam int IDX_W    = $clog2(RES_W);
    localparam logic [CNT_W-1:0] RES_W_C    = CNT_W'(RES_W);
    localparam logic [CNT_W-1:0] CONV_END   = CNT_W'(CONV_CLKS - 1);
    localparam logic [CNT_W-1:0] LEAD_END   = CNT_W'(CAL_LEAD_CLKS - 1);
    localparam logic [RES_W-1:0] MSB_ONE    = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] data;
        logic [RES_W-1:0] calw;
        logic             bip;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [1:0]       rise;
    logic             conv_rise, cal_rise;
    logic [CNT_W-1:0] mode_len;
    logic [CNT_W-1:0] cal_off;
    logic             sar_en;
    logic [IDX_W-1:0] sar_idx;
    logic [RES_W-1:0] sar_nxt;
    logic [RES_W-1:0] coded;

    adc_edge_det #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({cal_n, conv_start}),
        .rise (rise)
    );
    assign conv_rise = rise[0];
    assign cal_rise  = rise[1];

    adc_cal_len #(
        .CNT_W        (CNT_W),
        .CAL_FULL_CLKS(CAL_FULL_CLKS),
        .CAL_DAC_CLKS (CAL_DAC_CLKS),
        .CAL_OFS_CLKS (CAL_OFS_CLKS)
    ) u_len (
        .mode(cal_mode),
        .len (mode_len)
    );

    adc_sar_step #(.W(RES_W), .IDX_W(IDX_W)) u_sar (
        .trial(q.trial),
        .en   (sar_en),
        .idx  (sar_idx),
        .cmp  (cmp_hi),
        .nxt  (sar_nxt)
    );

    adc_out_coder #(.W(RES_W)) u_code (
        .code (q.trial),
        .bip  (q.bip),
        .coded(coded)
    );

    // Which search step applies in the current cycle
    assign cal_off = q.cnt - (q.len - RES_W_C);
    always_comb begin
        sar_en  = 1'b0;
        sar_idx = '0;
        if (q.st == ST_CONV && q.cnt < RES_W_C) begin
            sar_en  = 1'b1;
            sar_idx = q.cnt[IDX_W-1:0];
        end else if (q.st == ST_CAL_RUN && q.cnt >= q.len - RES_W_C) begin
            sar_en  = 1'b1;
            sar_idx = cal_off[IDX_W-1:0];
        end
    end

    // Next-state process
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (!sleep_n) begin
                    d.st = ST_SLEEP;
                end else if (conv_rise) begin
                    d.st    = ST_CONV;
                    d.cnt   = '0;
                    d.trial = MSB_ONE;
                    d.bip   = range_bip;
                end
            end
            ST_SLEEP: begin
                if (sleep_n) d.st = ST_IDLE;
            end
            ST_CONV: begin
                d.trial = sar_nxt;
                if (q.cnt == CONV_END) begin
                    d.st   = ST_IDLE;
                    d.data = coded;
                    d.cnt  = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CAL_DLY: begin
                if (q.cnt == LEAD_END) begin
                    d.st    = ST_CAL_RUN;
                    d.cnt   = '0;
                    d.trial = MSB_ONE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CAL_RUN: begin
                d.trial = sar_nxt;
                if (q.cnt == q.len - 1'b1) begin
                    d.st   = ST_IDLE;
                    d.calw = sar_nxt;
                    d.cnt  = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // Calibration control overrides every other operation
        if (!cal_n) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else if (cal_rise) begin
            d.st  = ST_CAL_DLY;
            d.cnt = '0;
            d.len = mode_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cnt   <= '0;
            q.len   <= '0;
            q.trial <= '0;
            q.data  <= '0;
            q.calw  <= '0;
            q.bip   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dac_code     = q.trial;
    assign hold         = (q.st == ST_CONV);
    assign busy         = (q.st == ST_CONV) || (q.st == ST_CAL_RUN);
    assign data_out     = q.data;
    assign cal_word     = q.calw;
    assign powered_down = (q.st == ST_SLEEP);

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && conv_rise && cal_n && !cal_rise && sleep_n) |=> (busy && hold)); // R2
    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_out)); // R3
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && conv_rise && cal_n && q.cnt != CONV_END) |=> hold); // R5
    AST_CAL_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_n |=> (!busy && !hold && !powered_down)); // R6
    AST_CAL_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cal_rise |=> !busy); // R7
    AST_SLEEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down |-> !busy); // R9
    AST_SLEEP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (powered_down && $past(powered_down)) |-> ($stable(cal_word) && $stable(data_out))); // R10
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int RW    = 12;
    localparam int LFULL = 40;
    localparam int LDAC  = 30;
    localparam int LOFS  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_start = 1'b0;
    logic          cal_n = 1'b1;
    logic          sleep_n = 1'b1;
    logic          range_bip = 1'b0;
    logic [1:0]    cal_mode = 2'b00;
    logic          cmp_hi;
    logic [RW-1:0] dac_code, data_out, cal_word;
    logic          hold, busy, powered_down;
    logic [RW-1:0] vin = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Behavioural comparator: input at or above the trial code
    assign cmp_hi = (vin >= dac_code);

    adc_seq_ctrl #(
        .RES_W(RW), .CONV_CLKS(18),
        .CAL_FULL_CLKS(LFULL), .CAL_DAC_CLKS(LDAC), .CAL_OFS_CLKS(LOFS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cal_n(cal_n),
        .sleep_n(sleep_n), .range_bip(range_bip), .cal_mode(cal_mode),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .hold(hold), .busy(busy),
        .data_out(data_out), .cal_word(cal_word), .powered_down(powered_down)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(input int v, input bit bip);
        return bip ? (v ^ 2048) : v;
    endfunction

    // R2 R3 R4: one conversion, busy periods counted, result read after fall
    task automatic run_conv(input int v, input bit bip);
        int bcnt = 0;
        @(negedge clk);
        vin = RW'(v); range_bip = bip; conv_start = 1'b1;
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            if (i == 0) conv_start = 1'b0;
            if (busy && hold) bcnt++;
        end
        check(bcnt == 18, "R2 busy length", bcnt, 18);
        check(data_out == RW'(expect_code(v, bip)), bip ? "R4 two's complement" : "R3 binary result",
              int'(data_out), expect_code(v, bip));
    endtask

    // R7 R8: calibration timing and search outcome
    task automatic run_cal(input logic [1:0] m, input int v, input int len);
        int first = -1;
        int bcnt  = 0;
        @(negedge clk);
        vin = RW'(v); cal_mode = m; cal_n = 1'b0;
        @(negedge clk);
        check(!busy, "R6 busy low with cal_n low", int'(busy), 0);
        @(negedge clk);
        cal_n = 1'b1;
        for (int i = 0; i < len + 3; i++) begin
            @(negedge clk);
            if (busy) begin
                bcnt++;
                if (first < 0) first = i;
            end
        end
        check(first == 2, "R7 busy lead delay", first, 2);
        check(bcnt == len, "R7 calibration length", bcnt, len);
        check(cal_word == RW'(v), "R8 calibration word", int'(cal_word), v);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int bcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !hold && !powered_down, "R1 flags", int'({busy, hold, powered_down}), 0);
        check(data_out == 0 && cal_word == 0 && dac_code == 0, "R1 words",
              int'(data_out) + int'(cal_word) + int'(dac_code), 0);

        // R3 R4 sweep over codes in both ranges, plus corners
        for (int v = 0; v < 4096; v += 13) begin
            run_conv(v, 1'b0);
            run_conv(v, 1'b1);
        end
        run_conv(4095, 1'b0); run_conv(4095, 1'b1);
        run_conv(2048, 1'b1); run_conv(2047, 1'b1);
        run_conv(0, 1'b1);

        // R5 restart during conversion is ignored
        @(negedge clk);
        vin = 12'd1234; range_bip = 1'b0; conv_start = 1'b1;
        bcnt = 0;
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            if (i == 0) conv_start = 1'b0;
            if (i == 4) conv_start = 1'b1;
            if (i == 6) conv_start = 1'b0;
            if (busy) bcnt++;
        end
        check(bcnt == 18, "R5 length kept", bcnt, 18);
        check(data_out == 12'd1234, "R5 result kept", int'(data_out), 1234);

        // R7 R8 every calibration mode
        run_cal(2'b00, 777, LFULL);
        run_cal(2'b01, 4095, LDAC);
        run_cal(2'b10, 0, LOFS);
        run_cal(2'b11, 2049, LFULL);

        // R6 calibration low aborts a conversion and blocks starts
        run_conv(100, 1'b0);
        @(negedge clk);
        vin = 12'd3000; conv_start = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 0) conv_start = 1'b0;
        end
        cal_n = 1'b0;
        @(negedge clk);
        check(!busy && !hold, "R6 abort", int'({busy, hold}), 0);
        conv_start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!busy, "R6 start ignored", int'(busy), 0);
        check(data_out == 12'd100, "R6 result kept", int'(data_out), 100);
        conv_start = 1'b0;
        vin = 12'd321;
        cal_mode = 2'b10;
        cal_n = 1'b1;
        repeat (LOFS + 4) @(negedge clk);
        check(cal_word == 12'd321, "R8 word after abort", int'(cal_word), 321);

        // R9 sleep requested mid-conversion is deferred
        @(negedge clk);
        vin = 12'd555; range_bip = 1'b0; conv_start = 1'b1;
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            if (i == 0) conv_start = 1'b0;
            if (i == 3) sleep_n = 1'b0;
            if (i >= 3 && i < 18)
                check(!powered_down && busy, "R9 deferred", int'(powered_down), 0);
        end
        check(!powered_down && !busy, "R9 idle edge", int'({powered_down, busy}), 0);
        check(data_out == 12'd555, "R9 result", int'(data_out), 555);
        @(negedge clk);
        check(powered_down, "R9 asleep", int'(powered_down), 1);

        // R10 asleep: starts ignored, state retained, wake
        conv_start = 1'b1;
        vin = 12'd9;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 1) conv_start = 1'b0;
            if (i == 5) conv_start = 1'b1;
            if (busy) check(1'b0, "R10 busy in sleep", 1, 0);
        end
        conv_start = 1'b0;
        check(data_out == 12'd555, "R10 result kept", int'(data_out), 555);
        check(cal_word == 12'd321, "R10 cal word kept", int'(cal_word), 321);
        sleep_n = 1'b1;
        @(negedge clk);
        check(!powered_down, "R10 wake", int'(powered_down), 0);
        run_conv(9, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule